// File: doc/BRIEF.md
# Four-Cell Rotating Self-Test Diagnoser

The block drives an on-line self test of a 2x2 tile of four small logic cells, numbered 0 to 3 (A to D). One test run is made of four sessions. In every session one cell produces the input patterns, two cells evaluate their lookup function on those patterns, and the fourth cell compares the two results. The roles rotate from session to session, so every cell is evaluated twice and produces patterns once.

Each session applies all input combinations of the cells, one per clock, and registers the comparator bit one cycle later. Any mismatch bit marks the session as failed. After the fourth session the four session results are decoded without any adaptive step: all passing means the tile is clean, a pattern in which exactly one cell has both evaluation sessions failing and its pattern session passing names that cell, and anything else is flagged undiagnosable. The cells are behavioural lookup tables with a per-cell stuck output that the environment can force, so single and multiple faults can be exercised.

Top module: `tile_selftest_diag`

## Requirements
- R1: In session s (0..3) cell s generates patterns, cells (s+1) mod 4 and (s+2) mod 4 are evaluated, and cell (s+3) mod 4 compares; bit s of sess_fail_o reports session s.
- R2: Each session applies all 2^N_IN input vectors (8 by default) and sess_fail_o[s] is 1 exactly when at least one registered comparator bit of that session is 1.
- R3: A stuck pattern generator feeds one constant pattern to both evaluated cells, so it makes its own session pass.
- R4: When all four sessions pass, no_fault_o is 1 and fault_valid_o and undiag_o are 0.
- R5: When for exactly one cell c sessions (c+3) mod 4 and (c+2) mod 4 fail and session c passes, fault_valid_o is 1 and fault_idx_o equals c; any single stuck cell is named this way.
- R6: Any other failing pattern sets undiag_o with fault_valid_o and no_fault_o at 0; after each run exactly one of the three verdict flags is 1.
- R7: done_o is a one-cycle pulse that goes high 37 clock edges after the edge that samples start_i (4 sessions of 8 vector cycles plus 1 flush cycle, plus one decode cycle).
- R8: start_i while a run is in progress is ignored: the run continues and finishes at its original time with its original result.
- R9: After reset all outputs are 0.
- R10: The verdict outputs and sess_fail_o hold their value between done_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle |
| stuck_en_i | input | 4 | Per-cell stuck-output fault enable |
| stuck_val_i | input | 4 | Per-cell stuck output value |
| done_o | output | 1 | One-cycle pulse when the verdict is updated |
| fault_valid_o | output | 1 | A single faulty cell was identified |
| fault_idx_o | output | 2 | Index of the faulty cell |
| no_fault_o | output | 1 | All sessions passed |
| undiag_o | output | 1 | Failure pattern matches no single cell |
| sess_fail_o | output | 4 | Per-session fail result of the last run |

## Verification
A wrong role rotation or a lost mismatch bit shows up in sess_fail_o and the verdict at the next done_o pulse, 37 cycles after start, because every fault configuration yields a fixed session pattern. The bench sweeps all 81 combinations of none, stuck-at-0 and stuck-at-1 on the four cells, so single faults test the naming and multiple faults test the undiagnosable path. A sequencing error such as a missing flush cycle or a restart on a late start pulse appears as a shifted done_o pulse or a missing last-vector mismatch.

// File: rtl/tile_diag_pkg.sv
package tile_diag_pkg;
  localparam int unsigned N_CELL = 4;
  localparam int unsigned IDX_W  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH,
    ST_FIN
  } seq_state_e;

  // cell holding a role offset from the generator in a session
  function automatic logic [IDX_W-1:0] cell_at(input logic [IDX_W-1:0] sess,
                                               input logic [IDX_W-1:0] off);
    return sess + off;
  endfunction
endpackage

// File: rtl/tile_cell.sv
module tile_cell #(
  parameter int unsigned               N_IN     = 3,
  parameter logic [(1<<N_IN)-1:0]      LUT_INIT = '0
) (
  input  logic [N_IN-1:0] cnt_i,
  input  logic [N_IN-1:0] x_i,
  input  logic            a_i,
  input  logic            b_i,
  input  logic            stuck_en_i,
  input  logic            stuck_val_i,
  output logic [N_IN-1:0] pat_o,
  output logic            lut_o,
  output logic            cmp_o
);
  // a stuck output forces every role's output
  always_comb begin
    pat_o = stuck_en_i ? {N_IN{stuck_val_i}} : cnt_i;
    lut_o = stuck_en_i ? stuck_val_i : LUT_INIT[x_i];
    cmp_o = stuck_en_i ? stuck_val_i : (a_i ^ b_i);
  end
endmodule

// File: rtl/tile_seq.sv
module tile_seq
  import tile_diag_pkg::*;
#(
  parameter int unsigned N_IN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mm_i,
  output logic [IDX_W-1:0] sess_o,
  output logic [N_IN-1:0]  vec_o,
  output logic             fin_o,
  output logic [N_CELL-1:0] fail_o
);
  localparam logic [N_IN-1:0]  VEC_LAST  = N_IN'((1 << N_IN) - 1);
  localparam logic [IDX_W-1:0] SESS_LAST = IDX_W'(N_CELL - 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  sess_q;
  logic [N_IN-1:0]   vec_q;
  logic              mm_q, mm_vld_q;
  logic [N_CELL-1:0] fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sess_q   <= '0;
      vec_q    <= '0;
      mm_q     <= 1'b0;
      mm_vld_q <= 1'b0;
      fail_q   <= '0;
    end else begin
      mm_q     <= mm_i;
      mm_vld_q <= (state_q == ST_RUN);
      if (mm_vld_q && mm_q) fail_q[sess_q] <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          sess_q  <= '0;
          vec_q   <= '0;
          fail_q  <= '0;
        end
        ST_RUN: begin
          vec_q <= vec_q + 1'b1;
          if (vec_q == VEC_LAST) state_q <= ST_FLUSH;
        end
        ST_FLUSH: begin
          if (sess_q == SESS_LAST) begin
            state_q <= ST_FIN;
          end else begin
            state_q <= ST_RUN;
            sess_q  <= sess_q + 1'b1;
            vec_q   <= '0;
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sess_o = sess_q;
  assign vec_o  = vec_q;
  assign fin_o  = (state_q == ST_FIN);
  assign fail_o = fail_q;

  p_flush_after_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && vec_q == VEC_LAST) |=> state_q == ST_FLUSH);

  p_run_not_restarted_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && vec_q != VEC_LAST) |=>
      (state_q == ST_RUN && vec_q == $past(vec_q) + 1'b1 && sess_q == $past(sess_q)));

  p_sess_advance_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FLUSH && sess_q != SESS_LAST) |=> sess_q == $past(sess_q) + 1'b1);
endmodule

// File: rtl/tile_decode.sv
module tile_decode
  import tile_diag_pkg::*;
(
  input  logic [N_CELL-1:0] fail_i,
  output logic              none_o,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              undiag_o
);
  logic [N_CELL-1:0] hit;

  for (genvar c = 0; c < N_CELL; c++) begin : g_sig
    localparam int unsigned T0 = (c + N_CELL - 1) % N_CELL;
    localparam int unsigned T1 = (c + N_CELL - 2) % N_CELL;
    // evaluated twice and failing both, generator session clean
    assign hit[c] = fail_i[T0] & fail_i[T1] & ~fail_i[c];
  end

  always_comb begin
    idx_o = '0;
    for (int c = 0; c < N_CELL; c++) begin
      if (hit[c]) idx_o = IDX_W'(c);
    end
    none_o   = (fail_i == '0);
    valid_o  = |hit;
    undiag_o = ~none_o & ~valid_o;
  end

  always_comb begin
    p_unique_sig_r5: assert ($onehot0(hit));
  end
endmodule

// File: rtl/tile_selftest_diag.sv
module tile_selftest_diag
  import tile_diag_pkg::*;
#(
  parameter int unsigned          N_IN     = 3,
  parameter logic [(1<<N_IN)-1:0] LUT_INIT = 8'h96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_CELL-1:0] stuck_en_i,
  input  logic [N_CELL-1:0] stuck_val_i,
  output logic              done_o,
  output logic              fault_valid_o,
  output logic [IDX_W-1:0]  fault_idx_o,
  output logic              no_fault_o,
  output logic              undiag_o,
  output logic [N_CELL-1:0] sess_fail_o
);
  logic [IDX_W-1:0]  sess;
  logic [N_IN-1:0]   vec;
  logic              fin;
  logic [N_CELL-1:0] fail;
  logic [IDX_W-1:0]  gen_idx, cut0_idx, cut1_idx, cmp_idx;
  logic [N_IN-1:0]   pat [N_CELL];
  logic              lut_b [N_CELL];
  logic              cmp_b [N_CELL];
  logic [N_IN-1:0]   pattern;
  logic              mm;
  logic              dec_none, dec_valid, dec_undiag;
  logic [IDX_W-1:0]  dec_idx;

  assign gen_idx  = cell_at(sess, 2'd0);
  assign cut0_idx = cell_at(sess, 2'd1);
  assign cut1_idx = cell_at(sess, 2'd2);
  assign cmp_idx  = cell_at(sess, 2'd3);

  assign pattern = pat[gen_idx];
  assign mm      = cmp_b[cmp_idx];

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    tile_cell #(.N_IN(N_IN), .LUT_INIT(LUT_INIT)) u_cell (
      .cnt_i      (vec),
      .x_i        (pattern),
      .a_i        (lut_b[cut0_idx]),
      .b_i        (lut_b[cut1_idx]),
      .stuck_en_i (stuck_en_i[c]),
      .stuck_val_i(stuck_val_i[c]),
      .pat_o      (pat[c]),
      .lut_o      (lut_b[c]),
      .cmp_o      (cmp_b[c])
    );
  end

  tile_seq #(.N_IN(N_IN)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .mm_i   (mm),
    .sess_o (sess),
    .vec_o  (vec),
    .fin_o  (fin),
    .fail_o (fail)
  );

  tile_decode u_dec (
    .fail_i  (fail),
    .none_o  (dec_none),
    .valid_o (dec_valid),
    .idx_o   (dec_idx),
    .undiag_o(dec_undiag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      fault_valid_o <= 1'b0;
      fault_idx_o   <= '0;
      no_fault_o    <= 1'b0;
      undiag_o      <= 1'b0;
      sess_fail_o   <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        fault_valid_o <= dec_valid;
        fault_idx_o   <= dec_idx;
        no_fault_o    <= dec_none;
        undiag_o      <= dec_undiag;
        sess_fail_o   <= fail;
      end
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_one_verdict_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({no_fault_o, fault_valid_o, undiag_o}) == 1);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({no_fault_o, fault_valid_o, undiag_o, fault_idx_o, sess_fail_o}));

  p_clean_verdict_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sess_fail_o == '0) |-> no_fault_o);
endmodule

// File: tb/test_tile_selftest_diag.sv
`timescale 1ns/1ps
module test_tile_selftest_diag;
  localparam logic [7:0] LUT = 8'h96;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] stuck_en_i = '0;
  logic [3:0] stuck_val_i = '0;
  logic       done_o, fault_valid_o, no_fault_o, undiag_o;
  logic [1:0] fault_idx_o;
  logic [3:0] sess_fail_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk_i = ~clk_i;

  tile_selftest_diag i_tile_selftest_diag (
    .clk_i, .rst_ni, .start_i, .stuck_en_i, .stuck_val_i,
    .done_o, .fault_valid_o, .fault_idx_o, .no_fault_o, .undiag_o, .sess_fail_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // per-session fail from the role rule and exhaustive vectors
  function automatic logic [3:0] model_fail(input logic [3:0] en, input logic [3:0] val);
    logic [3:0] f = '0;
    for (int s = 0; s < 4; s++) begin
      int g = s, c0 = (s + 1) % 4, c1 = (s + 2) % 4, m = (s + 3) % 4;
      for (int v = 0; v < 8; v++) begin
        logic [2:0] p;
        logic o0, o1, x;
        p  = en[g] ? {3{val[g]}} : 3'(v);
        o0 = en[c0] ? val[c0] : LUT[p];
        o1 = en[c1] ? val[c1] : LUT[p];
        x  = en[m] ? val[m] : (o0 ^ o1);
        f[s] = f[s] | x;
      end
    end
    return f;
  endfunction

  task automatic run_one(input logic [3:0] en, input logic [3:0] val, input bit poke);
    int n = 0;
    logic [3:0] ef;
    int hits = 0, hidx = 0;
    logic [6:0] snap;
    stuck_en_i  = en;
    stuck_val_i = val;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    while (n < 100) begin
      @(negedge clk_i);
      n++;
      if (poke && n == 10) start_i = 1'b1;
      if (poke && n == 11) start_i = 1'b0;
      if (done_o) break;
    end
    chk(n == 37, poke ? "R8 late start" : "R7 latency", n, 37);
    ef = model_fail(en, val);
    chk(sess_fail_o == ef, "R2 session fails", sess_fail_o, ef);
    for (int c = 0; c < 4; c++) begin
      if (ef[(c + 3) % 4] && ef[(c + 2) % 4] && !ef[c]) begin
        hits++;
        hidx = c;
      end
    end
    if (ef == 4'b0) begin
      chk(no_fault_o && !fault_valid_o && !undiag_o, "R4 clean", {no_fault_o, fault_valid_o, undiag_o}, 4);
    end else if (hits == 1) begin
      chk(fault_valid_o && !no_fault_o && !undiag_o && fault_idx_o == 2'(hidx), "R5 named",
          fault_idx_o, hidx);
    end else begin
      chk(undiag_o && !fault_valid_o && !no_fault_o, "R6 undiag", {no_fault_o, fault_valid_o, undiag_o}, 1);
    end
    if ($countones(en) == 1) begin
      for (int c = 0; c < 4; c++) begin
        if (en[c]) begin
          chk(fault_valid_o && fault_idx_o == 2'(c), "R5 single cell", fault_idx_o, c);
          chk(sess_fail_o[(c + 3) % 4] && sess_fail_o[(c + 2) % 4], "R1 evaluated sessions fail",
              sess_fail_o, c);
          chk(!sess_fail_o[c], "R3 generator session passes", sess_fail_o[c], 0);
        end
      end
    end
    snap = {no_fault_o, fault_valid_o, undiag_o, sess_fail_o};
    @(negedge clk_i);
    chk(!done_o, "R7 pulse width", done_o, 0);
    repeat (3) @(negedge clk_i);
    chk({no_fault_o, fault_valid_o, undiag_o, sess_fail_o} == snap, "R10 hold",
        {no_fault_o, fault_valid_o, undiag_o, sess_fail_o}, snap);
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({done_o, fault_valid_o, no_fault_o, undiag_o, fault_idx_o, sess_fail_o} == '0,
        "R9 reset", {done_o, fault_valid_o, no_fault_o, undiag_o, fault_idx_o, sess_fail_o}, 0);
    for (int k = 0; k < 81; k++) begin
      logic [3:0] en = '0, val = '0;
      int r = k;
      for (int c = 0; c < 4; c++) begin
        en[c]  = (r % 3) != 0;
        val[c] = (r % 3) == 2;
        r = r / 3;
      end
      run_one(en, val, (k % 7) == 3);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule